// File: doc/BRIEF.md
# SM4 Key Schedule Round Unit

This block advances the SM4 key schedule by four words per operation. It takes the four most recent round-key words as one 128-bit group and a 5-bit immediate whose low three bits pick the round group. It returns the next four round-key words as a 128-bit group. Each new word comes from one step: the three newest words and a round constant are XORed, the result passes through the SM4 byte substitution, and the key-schedule linear transform is applied. The oldest word is then XORed into the result. The steps are strictly dependent, because every new word enters the XOR of the step that follows it.

The parameter `UNROLL` (1, 2 or 4) sets how many dependent steps are evaluated per clock. An operation therefore takes 4/`UNROLL` compute cycles. A start is accepted only while the unit is idle. A one-cycle done strobe marks the result, and the result stays on the output until the next accepted start. To run a whole schedule, feed each result back as the next input and step the round group from 0 to 7.

Top module: `sm4k_key_round`

## Requirements
- R1: Only `imm_i[2:0]` selects the round group r (0..7). Changing `imm_i[4:3]` never changes the result.
- R2: The input group holds the prior words w0..w3 as 32-bit lanes, with w0 in bits 31:0, w1 in 63:32, w2 in 95:64 and w3 in 127:96.
- R3: Step i (i = 0..3) uses the constant C[4r+i]. Byte j of C[n], counting from the most significant byte (j = 0..3), equals ((4n+j)*7) mod 256, so C[0] = 0x00070E15 and C[31] = 0x646B7279.
- R4: Step i produces w(i+4) = w(i) ^ L(S(w(i+1) ^ w(i+2) ^ w(i+3) ^ C[4r+i])). Here S applies the standard SM4 S-box to each byte (S(0x00) = 0xD6, S(0xFF) = 0x48), and L(x) = x ^ rotl(x,13) ^ rotl(x,23). The steps are evaluated in order, each one using the word made by the step before it.
- R5: The result packs w4 in bits 31:0, w5 in 63:32, w6 in 95:64 and w7 in 127:96. Starting from the standard test key XOR the system parameters, group 0 gives 0xF12186F9, 0x41662B61, 0x5A6AB19A and 0x7BA92077, and group 7 gives 0x01CF72E5 in w6 and 0x9124A012 in w7.
- R6: `done_o` rises exactly 4/`UNROLL` clock edges after the edge that accepts a start. It stays high for exactly one cycle.
- R7: A start is accepted only while `ready_o` is high. `ready_o` drops after the accepting edge. A start raised while the unit is busy has no effect on the result and produces no extra done.
- R8: After reset, `done_o` is 0, `ready_o` is 1 and `key_o` is 0.
- R9: `key_o` holds the last result from the done cycle until the next accepted start, whatever `key_i` and `imm_i` do in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when ready_o is high |
| imm_i | input | 5 | Immediate; bits 2:0 give the round group |
| key_i | input | 128 | Prior four round-key words, w0 in the low lane |
| ready_o | output | 1 | Unit idle, a start will be accepted |
| done_o | output | 1 | One-cycle strobe, result valid |
| key_o | output | 128 | Four new round-key words, w4 in the low lane |

## Verification
The bench runs the full eight-group schedule from the standard test key and compares the first and last groups with the known round keys. A swapped lane order, a wrong constant byte, a wrong rotation or a broken substitution byte would corrupt every later word, so such faults show up as mismatches there. It then repeats every group with all three nonzero values of the ignored immediate bits. A design that decoded four or five bits would fetch constants beyond entry 31 and fail these repeats. Separate runs raise a start with a different key while the unit is busy, and change the inputs while it sits idle after done. A design that reloaded while busy, or let the output track its inputs, would lose the known result or emit a second done. The bench also counts the done latency exactly and checks that the strobe is one cycle wide.

// File: rtl/sm4k_pkg.sv
`timescale 1ns/1ps
package sm4k_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WORDS   = 4;
  localparam int unsigned GROUP_W = WORD_W * WORDS;
  localparam int unsigned IMM_W   = 5;
  localparam int unsigned RND_W   = 3;
  localparam int unsigned IDX_W   = RND_W + 2;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [GROUP_W-1:0] group_t;
  typedef logic [RND_W-1:0]   rnd_t;
  typedef logic [IDX_W-1:0]   idx_t;

  // One 16-byte row of the substitution box per high nibble, entry 0 in the top byte.
  function automatic logic [127:0] sbox_row(input logic [3:0] hi);
    logic [127:0] r;
    case (hi)
      4'h0: r = 128'hd690e9fecce13db716b614c228fb2c05;
      4'h1: r = 128'h2b679a762abe04c3aa44132649860699;
      4'h2: r = 128'h9c4250f491ef987a33540b43edcfac62;
      4'h3: r = 128'he4b31ca9c908e89580df94fa758f3fa6;
      4'h4: r = 128'h4707a7fcf37317ba83593c19e6854fa8;
      4'h5: r = 128'h686b81b27164da8bf8eb0f4b70569d35;
      4'h6: r = 128'h1e240e5e6358d1a225227c3b01217887;
      4'h7: r = 128'hd40046579fd327524c3602e7a0c4c89e;
      4'h8: r = 128'heabf8ad240c738b5a3f7f2cef96115a1;
      4'h9: r = 128'he0ae5da49b341a55ad933230f58cb1e3;
      4'ha: r = 128'h1df6e22e8266ca60c02923ab0d534e6f;
      4'hb: r = 128'hd5db3745defd8e2f03ff6a726d6c5b51;
      4'hc: r = 128'h8d1baf92bbddbc7f11d95c411f105ad8;
      4'hd: r = 128'h0ac13188a5cd7bbd2d74d012b8e5b4b0;
      4'he: r = 128'h8969974a0c96777e65b9f109c56ec684;
      default: r = 128'h18f07dec3adc4d2079ee5f3ed7cb3948;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [127:0] r;
    r = sbox_row(x[7:4]);
    return r[{~x[3:0], 3'b000} +: 8];
  endfunction

  // Round constant: byte j (MSB first) of entry n is ((4n+j)*7) mod 256.
  function automatic word_t ck_word(input idx_t n);
    word_t w;
    logic [7:0] pos;
    logic [7:0] b;
    w = '0;
    for (int j = 0; j < 4; j++) begin
      pos = {1'b0, n, 2'b00} + 8'(j);
      b   = pos * 8'd7;
      w[8*(3-j) +: 8] = b;
    end
    return w;
  endfunction

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/sm4k_sbox32.sv
`timescale 1ns/1ps
module sm4k_sbox32
  import sm4k_pkg::*;
(
  input  word_t x_i,
  output word_t y_o
);
  for (genvar b = 0; b < WORDS; b++) begin : g_byte
    assign y_o[8*b +: 8] = sbox(x_i[8*b +: 8]);
  end
endmodule

// File: rtl/sm4k_step.sv
`timescale 1ns/1ps
module sm4k_step
  import sm4k_pkg::*;
(
  input  group_t win_i,
  input  word_t  ck_i,
  output word_t  new_o
);
  word_t mix;
  word_t sub;

  assign mix = win_i[1*WORD_W +: WORD_W] ^ win_i[2*WORD_W +: WORD_W]
             ^ win_i[3*WORD_W +: WORD_W] ^ ck_i;

  sm4k_sbox32 u_sbox (
    .x_i (mix),
    .y_o (sub)
  );

  assign new_o = win_i[0 +: WORD_W] ^ sub ^ rotl(sub, 13) ^ rotl(sub, 23);
endmodule

// File: rtl/sm4k_chain.sv
`timescale 1ns/1ps
module sm4k_chain
  import sm4k_pkg::*;
#(
  parameter int unsigned UNROLL = 1
) (
  input  group_t win_i,
  input  idx_t   base_i,
  output group_t win_o
);
  group_t win [UNROLL+1];

  assign win[0] = win_i;

  for (genvar k = 0; k < UNROLL; k++) begin : g_step
    word_t ck;
    word_t nxt;
    assign ck = ck_word(base_i + IDX_W'(k));
    sm4k_step u_step (
      .win_i (win[k]),
      .ck_i  (ck),
      .new_o (nxt)
    );
    // Oldest word drops out of the low lane, new word enters the top lane.
    assign win[k+1] = {nxt, win[k][GROUP_W-1:WORD_W]};
  end

  assign win_o = win[UNROLL];
endmodule

// File: rtl/sm4k_key_round.sv
`timescale 1ns/1ps
module sm4k_key_round
  import sm4k_pkg::*;
#(
  parameter int unsigned UNROLL = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [GROUP_W-1:0]  key_i,
  output logic                ready_o,
  output logic                done_o,
  output logic [GROUP_W-1:0]  key_o
);
  localparam int unsigned NCYC  = WORDS / UNROLL;
  localparam int unsigned CNT_W = (NCYC > 1) ? $clog2(NCYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NCYC - 1);

  group_t            state_q;
  rnd_t              rnd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              done_q;
  idx_t              base_idx;
  group_t            chain_out;
  logic              unused_imm;

  assign unused_imm = ^imm_i[IMM_W-1:RND_W];

  assign base_idx = {rnd_q, 2'b00} + IDX_W'(cnt_q) * IDX_W'(UNROLL);

  sm4k_chain #(.UNROLL(UNROLL)) u_chain (
    .win_i  (state_q),
    .base_i (base_idx),
    .win_o  (chain_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      rnd_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          state_q <= key_i;
          rnd_q   <= imm_i[RND_W-1:0];
          cnt_q   <= '0;
          busy_q  <= 1'b1;
        end
      end else begin
        state_q <= chain_out;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ready_o = !busy_q;
  assign done_o  = done_q;
  assign key_o   = state_q;
endmodule

// File: rtl/sm4k_key_round_chk.sv
`timescale 1ns/1ps
module sm4k_key_round_chk #(
  parameter int unsigned NCYC = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         ready_o,
  input logic         done_o,
  input logic [127:0] key_o
);
  logic [3:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        lat_q <= '0;
    else if (start_i && ready_o)        lat_q <= '0;
    else if (!ready_o && lat_q != 4'hF) lat_q <= lat_q + 4'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == 4'(NCYC)); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!ready_o)); // R6
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(key_o)); // R9
endmodule

bind sm4k_key_round sm4k_key_round_chk #(.NCYC(4 / UNROLL)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .key_o   (key_o)
);

// File: tb/test_sm4k_key_round.sv
`timescale 1ns/1ps
module test_sm4k_key_round;
  localparam int UNROLL = 1;
  localparam int NCYC   = 4 / UNROLL;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [4:0]   imm_i;
  logic [127:0] key_i;
  logic         ready_o;
  logic         done_o;
  logic [127:0] key_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  sm4k_key_round #(.UNROLL(UNROLL)) i_sm4k_key_round (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .imm_i   (imm_i),
    .key_i   (key_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .key_o   (key_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] k, input logic [4:0] imm,
                        output logic [127:0] res, output int lat);
    @(negedge clk_i);
    start_i = 1'b1; key_i = k; imm_i = imm;
    @(negedge clk_i);
    start_i = 1'b0; key_i = ~k; imm_i = ~imm;
    lat = 0;
    while (!done_o && lat < 32) begin
      @(negedge clk_i);
      lat++;
    end
    res = key_o;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] mk, fk, res;
    logic [127:0] sched [9];
    int lat, dones;

    rst_ni = 1'b0; start_i = 1'b0; imm_i = '0; key_i = '0;
    repeat (3) @(negedge clk_i);
    check("R8 done in reset", 128'(done_o), 128'd0);
    check("R8 ready in reset", 128'(ready_o), 128'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 done after reset", 128'(done_o), 128'd0);
    check("R8 ready after reset", 128'(ready_o), 128'd1);
    check("R8 key after reset", key_o, 128'd0);

    // Standard key XOR system parameters, w0 in the low lane (R2).
    mk = {32'h76543210, 32'hFEDCBA98, 32'h89ABCDEF, 32'h01234567};
    fk = {32'hB27022DC, 32'h677D9197, 32'h56AA3350, 32'hA3B1BAC6};
    sched[0] = mk ^ fk;

    // Full schedule, groups 0..7 (R2..R6).
    for (int r = 0; r < 8; r++) begin
      run_op(sched[r], 5'(r), res, lat);
      sched[r+1] = res;
      check("R6 latency", 128'(lat), 128'(NCYC));
      @(negedge clk_i);
      check("R6 done one cycle", 128'(done_o), 128'd0);
    end
    check("R5 w4 group0", 128'(sched[1][31:0]),   128'(32'hF12186F9));
    check("R5 w5 group0", 128'(sched[1][63:32]),  128'(32'h41662B61));
    check("R4 w6 group0", 128'(sched[1][95:64]),  128'(32'h5A6AB19A));
    check("R4 w7 group0", 128'(sched[1][127:96]), 128'(32'h7BA92077));
    check("R3 w6 group7", 128'(sched[8][95:64]),  128'(32'h01CF72E5));
    check("R3 w7 group7", 128'(sched[8][127:96]), 128'(32'h9124A012));

    // Upper immediate bits ignored, all groups and all upper values (R1).
    for (int r = 0; r < 8; r++) begin
      for (int hi = 1; hi < 4; hi++) begin
        run_op(sched[r], {2'(hi), 3'(r)}, res, lat);
        check("R1 upper imm bits ignored", res, sched[r+1]);
      end
    end

    // Start while busy is ignored (R7).
    @(negedge clk_i);
    start_i = 1'b1; key_i = sched[0]; imm_i = 5'd0;
    @(negedge clk_i);
    check("R7 ready low after accept", 128'(ready_o), 128'd0);
    key_i = ~sched[0]; imm_i = 5'd5;
    lat = 0;
    while (!done_o && lat < 32) begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    start_i = 1'b0;
    check("R7 result with busy start", key_o, sched[1]);
    check("R7 latency with busy start", 128'(lat), 128'(NCYC));
    dones = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk_i);
      if (done_o) dones++;
    end
    check("R7 no extra done", 128'(dones), 128'd0);

    // Output held while idle and inputs move (R9).
    res = key_o;
    for (int c = 0; c < 6; c++) begin
      key_i = {4{32'(c * 32'h9E3779B9)}}; imm_i = 5'(c);
      @(negedge clk_i);
    end
    check("R9 key held while idle", key_o, res);
    check("R9 ready while idle", 128'(ready_o), 128'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule